// File: doc/BRIEF.md
# Multi-Address I2C Target Address Matcher

This block listens to an I2C bus as a target. After every START or repeated START it shifts in the first byte and compares its 7-bit address against ten programmable own-address slots, the general-call address and the fixed SMBus ARP address. When at least one enabled entry matches, it pulls SDA low for the ninth clock pulse to acknowledge. It also records which entries hit, in which direction the transfer runs, and whether the match came from a repeated START.

Software programs the slots and the enables through a small register port with write strobes and a combinational read. Three sticky event flags cover address match, stop and repeated start. Each flag is cleared by writing 1 to its bit, and each can be routed to the interrupt output through a mask. Data bytes after the address are not handled: the block lets go of SDA and waits for the next START or STOP.

Top module: `i2c_tgt_addr_match`

## Requirements
- R1: Registers 0 to 9 are address slots: bit 7 enables the slot and bits 6:0 hold its address. An enabled slot whose address equals the received 7-bit address causes SDA to be held low (`sda_oe`=1) for the whole ninth SCL pulse. A disabled slot never matches.
- R2: On a match, the set of slots that hit is captured. Slots 0 to 6 appear in register 13 bits 6:0 and slots 7 to 9 in register 14 bits 2:0. When several slots hold the same address, all of their bits are set.
- R3: General call (address 0x00) matches only when register 10 bit 0 is set. It is reported in status (register 12) bit 4, with the slot bits left clear.
- R4: The ARP address 0x61 matches only when register 10 bit 1 is set. It is reported in status bit 5, with the slot bits left clear.
- R5: Status bit 3 holds the R/W bit of the last matched address byte: 1 means the target transmits.
- R6: An address byte that nothing matches leaves SDA released and sets no flag.
- R7: Address bytes whose upper five bits are 11110 (10-bit headers) never match, even if a slot holds such an address.
- R8: A STOP seen after a matched address sets status bit 1 and ends the transaction. A STOP after an unmatched address sets nothing.
- R9: A START that arrives after a match and before any STOP sets status bit 2. A START that follows a STOP does not.
- R10: Status bits 2:0 are sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R11: `irq` is high exactly when some status bit among 2:0 is set and the matching bit of register 11 is set.
- R12: After reset every register reads 0, `sda_oe` is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as sampled from the pad |
| sda_i | input | 1 | Bus data line as sampled from the pad |
| sda_oe | output | 1 | Drive SDA low when 1 (open drain) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt: a masked event flag is set |

## Verification
If the bit sequencer ends up in the wrong state, the error shows on the bus within one byte. An acknowledge comes a pulse early or late, or it is missing, and a master watching the ninth pulse sees this right away. If the comparator or the capture registers go wrong, nothing shows on the bus. The error appears only when software reads the match registers after the address byte, as a wrong slot bitmap, direction bit or general-call/ARP bit. If the start/stop detector fails, the stop and repeated-start flags come out wrong, and that shows up only in the status read taken after the closing STOP.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int N_SLOTS = 10;
  localparam int LO_W    = 7;
  localparam int AW      = 4;

  localparam logic [6:0] ADDR_GC  = 7'h00;
  localparam logic [6:0] ADDR_ARP = 7'h61;
  localparam logic [4:0] TEN_HDR  = 5'b11110;

  localparam logic [AW-1:0] REG_CTRL = AW'(N_SLOTS);
  localparam logic [AW-1:0] REG_MASK = AW'(N_SLOTS + 1);
  localparam logic [AW-1:0] REG_STAT = AW'(N_SLOTS + 2);
  localparam logic [AW-1:0] REG_VLO  = AW'(N_SLOTS + 3);
  localparam logic [AW-1:0] REG_VHI  = AW'(N_SLOTS + 4);

  typedef enum logic [1:0] {FE_IDLE, FE_ADDR, FE_ACK, FE_SKIP} fe_state_t;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic start_p,
  output logic stop_p,
  output logic scl_rise,
  output logic scl_fall
);
  localparam int W = STAGES + 1;

  logic [W-1:0] scl_sh, sda_sh;
  logic scl_now, scl_old, sda_old;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[W-2:0], scl_i};
      sda_sh <= {sda_sh[W-2:0], sda_i};
    end
  end

  assign scl_now  = scl_sh[W-2];
  assign scl_old  = scl_sh[W-1];
  assign sda_s    = sda_sh[W-2];
  assign sda_old  = sda_sh[W-1];
  assign scl_rise = scl_now & ~scl_old;
  assign scl_fall = ~scl_now & scl_old;
  // SDA moving while SCL stays high marks a bus condition
  assign start_p  = scl_now & scl_old & sda_old & ~sda_s;
  assign stop_p   = scl_now & scl_old & ~sda_old & sda_s;
endmodule

// File: rtl/i2c_tgt_cmp.sv
module i2c_tgt_cmp
  import i2c_tgt_pkg::*;
(
  input  logic [N_SLOTS-1:0][7:0] slots,
  input  logic [6:0]              addr7,
  input  logic                    gc_en,
  input  logic                    arp_en,
  output logic [N_SLOTS-1:0]      slot_hit,
  output logic                    gc_hit,
  output logic                    arp_hit,
  output logic                    any_hit
);
  logic ten_hdr;
  assign ten_hdr = (addr7[6:2] == TEN_HDR);

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_cmp
    assign slot_hit[i] = slots[i][7] && (slots[i][6:0] == addr7) && !ten_hdr;
  end

  assign gc_hit  = gc_en  && (addr7 == ADDR_GC);
  assign arp_hit = arp_en && (addr7 == ADDR_ARP);
  assign any_hit = (|slot_hit) | gc_hit | arp_hit;
endmodule

// File: rtl/i2c_tgt_fe.sv
module i2c_tgt_fe
  import i2c_tgt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_p,
  input  logic       stop_p,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_s,
  input  logic       any_hit,
  output logic [7:0] addr_byte,
  output logic       sda_oe,
  output logic       ack_go,
  output logic       rstart_p,
  output logic       stop_evt_p
);
  fe_state_t  st_q, st_n;
  logic [3:0] cnt_q, cnt_n;
  logic [7:0] sh_q, sh_n;
  logic       oe_q, oe_n;
  logic       adr_q, adr_n;

  always_comb begin
    st_n = st_q; cnt_n = cnt_q; sh_n = sh_q; oe_n = oe_q; adr_n = adr_q;
    ack_go = 1'b0; rstart_p = 1'b0; stop_evt_p = 1'b0;
    if (start_p) begin
      rstart_p = adr_q;
      st_n = FE_ADDR; cnt_n = '0; oe_n = 1'b0;
    end else if (stop_p) begin
      stop_evt_p = adr_q;
      st_n = FE_IDLE; adr_n = 1'b0; oe_n = 1'b0;
    end else begin
      case (st_q)
        FE_ADDR: begin
          if (scl_rise && cnt_q < 4'd8) begin
            sh_n  = {sh_q[6:0], sda_s};
            cnt_n = cnt_q + 4'd1;
          end
          if (scl_fall && cnt_q == 4'd8) begin
            if (any_hit) begin
              st_n = FE_ACK; oe_n = 1'b1; ack_go = 1'b1; adr_n = 1'b1;
            end else begin
              st_n = FE_SKIP;
            end
          end
        end
        FE_ACK: if (scl_fall) begin
          oe_n = 1'b0; st_n = FE_SKIP;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= FE_IDLE; cnt_q <= '0; sh_q <= '0; oe_q <= 1'b0; adr_q <= 1'b0;
    end else begin
      st_q <= st_n; cnt_q <= cnt_n; sh_q <= sh_n; oe_q <= oe_n; adr_q <= adr_n;
    end
  end

  assign addr_byte = sh_q;
  assign sda_oe    = oe_q;

  // R7: an acknowledged byte is never a 10-bit header
  p_no_ten_bit_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> (sh_q[7:3] != TEN_HDR));
  // R8: a STOP ends the addressed transaction
  p_stop_ends_txn_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |=> !adr_q);
  // R1: acknowledge released at the end of the ninth pulse
  p_ack_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q && scl_fall) |=> !oe_q);
endmodule

// File: rtl/i2c_tgt_addr_match.sv
module i2c_tgt_addr_match
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          irq
);
  localparam int HI_W = N_SLOTS - LO_W;

  logic start_p, stop_p, scl_rise, scl_fall, sda_s;
  logic [7:0] slot_q [N_SLOTS];
  logic [N_SLOTS-1:0][7:0] slot_flat;
  logic [N_SLOTS-1:0] slot_hit, en_mask, vec_q, vec_n;
  logic gc_hit, arp_hit, any_hit;
  logic [7:0] addr_byte;
  logic ack_go, rstart_p, stop_evt_p;
  logic gc_en_q, arp_en_q;
  logic [2:0] mask_q, flg_q, flg_n, clr;
  logic dir_q, dir_n, gc_q, gc_n, arp_q, arp_n;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .start_p(start_p), .stop_p(stop_p), .scl_rise(scl_rise), .scl_fall(scl_fall));

  i2c_tgt_cmp u_cmp (
    .slots(slot_flat), .addr7(addr_byte[7:1]), .gc_en(gc_en_q), .arp_en(arp_en_q),
    .slot_hit(slot_hit), .gc_hit(gc_hit), .arp_hit(arp_hit), .any_hit(any_hit));

  i2c_tgt_fe u_fe (
    .clk(clk), .rst_n(rst_n), .start_p(start_p), .stop_p(stop_p),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s), .any_hit(any_hit),
    .addr_byte(addr_byte), .sda_oe(sda_oe), .ack_go(ack_go),
    .rstart_p(rstart_p), .stop_evt_p(stop_evt_p));

  // address slots, one write enable each
  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    logic we;
    assign we = reg_wr && (reg_addr == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  slot_q[i] <= '0;
      else if (we) slot_q[i] <= reg_wdata;
    end
    assign slot_flat[i] = slot_q[i];
    assign en_mask[i]   = slot_q[i][7];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gc_en_q <= 1'b0; arp_en_q <= 1'b0; mask_q <= '0;
    end else if (reg_wr) begin
      if (reg_addr == REG_CTRL) begin
        gc_en_q <= reg_wdata[0]; arp_en_q <= reg_wdata[1];
      end
      if (reg_addr == REG_MASK) mask_q <= reg_wdata[2:0];
    end
  end

  // status next state: event set wins over a same-cycle clear
  always_comb begin
    clr   = (reg_wr && reg_addr == REG_STAT) ? reg_wdata[2:0] : 3'b000;
    flg_n = (flg_q & ~clr) | {rstart_p, stop_evt_p, ack_go};
    vec_n = vec_q; dir_n = dir_q; gc_n = gc_q; arp_n = arp_q;
    if (ack_go) begin
      vec_n = slot_hit; dir_n = addr_byte[0]; gc_n = gc_hit; arp_n = arp_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= '0; vec_q <= '0; dir_q <= 1'b0; gc_q <= 1'b0; arp_q <= 1'b0;
    end else begin
      flg_q <= flg_n; vec_q <= vec_n; dir_q <= dir_n; gc_q <= gc_n; arp_q <= arp_n;
    end
  end

  assign irq = |(flg_q & mask_q);

  always_comb begin
    reg_rdata = '0;
    if (reg_addr < AW'(N_SLOTS)) reg_rdata = slot_q[reg_addr];
    else case (reg_addr)
      REG_CTRL: reg_rdata = {6'd0, arp_en_q, gc_en_q};
      REG_MASK: reg_rdata = {5'd0, mask_q};
      REG_STAT: reg_rdata = {2'd0, arp_q, gc_q, dir_q, flg_q};
      REG_VLO:  reg_rdata = {1'b0, vec_q[LO_W-1:0]};
      REG_VHI:  reg_rdata = {{(8-HI_W){1'b0}}, vec_q[N_SLOTS-1:LO_W]};
      default:  reg_rdata = '0;
    endcase
  end

  // R1: the bus acknowledge and the match flag appear together
  p_ack_sets_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> flg_q[0]);
  // R1/R2: captured bitmap only names slots that were enabled
  p_only_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> ((vec_q & ~$past(en_mask)) == '0));
  // R3/R4: general call and ARP are different addresses
  p_gc_arp_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(gc_q && arp_q));
endmodule

// File: tb/i2c_tgt_addr_match_bench.sv
`timescale 1ns/1ps
module i2c_tgt_addr_match_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, scl_m, sda_m, reg_wr;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata;
  wire  [7:0] reg_rdata;
  wire  sda_oe, irq;
  wire  sda_bus = sda_m & ~sda_oe;

  int checks = 0;
  int errors = 0;
  localparam int Q = 10;

  i2c_tgt_addr_match u_i2c_tgt_addr_match (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic m_start();
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl_m = 1'b0; wt(Q);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b1; wt(Q);
  endtask

  task automatic m_addr(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(Q); scl_m = 1'b1; wt(2*Q); scl_m = 1'b0; wt(Q);
    end
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q);
    ack = ~sda_bus;
    wt(Q); scl_m = 1'b0; wt(Q);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 15; a++) begin
      rd(4'(a), v); chk("R12 reset register", v, 0);
    end
    chk("R12 reset sda_oe", sda_oe, 0);
    chk("R12 reset irq", irq, 0);
  endtask

  task automatic t_slot_write();
    logic ack; logic [7:0] v;
    m_start(); m_addr(8'h54, ack);
    chk("R1 enabled slot acks", ack, 1);
    rd(4'd12, v); chk("R5 write direction, match set", v, 8'h01);
    m_stop();
    rd(4'd12, v); chk("R8 stop flag, R9 no rstart after fresh start", v, 8'h03);
    rd(4'd13, v); chk("R2 vector low (slot 3)", v, 8'h08);
    rd(4'd14, v); chk("R2 vector high (duplicate slot 8)", v, 8'h02);
  endtask

  task automatic t_w1c();
    logic [7:0] v;
    wr(4'd12, 8'h00); rd(4'd12, v); chk("R10 zero write keeps flags", v, 8'h03);
    wr(4'd12, 8'h01); rd(4'd12, v); chk("R10 clear match only", v, 8'h02);
    wr(4'd12, 8'h02); rd(4'd12, v); chk("R10 clear stop", v, 8'h00);
  endtask

  task automatic t_disabled();
    logic ack; logic [7:0] v;
    m_start(); m_addr(8'hA1, ack);
    chk("R1 disabled slot does not ack", ack, 0);
    chk("R6 sda released", sda_oe, 0);
    m_stop();
    rd(4'd12, v); chk("R6 no flags on miss, R8 no stop flag", v, 8'h00);
  endtask

  task automatic t_dir_read();
    logic ack; logic [7:0] v;
    m_start(); m_addr(8'h55, ack); m_stop();
    chk("R1 read address acks", ack, 1);
    rd(4'd12, v); chk("R5 read direction", v, 8'h0B);
    wr(4'd12, 8'h07);
  endtask

  task automatic t_gc();
    logic ack; logic [7:0] v;
    m_start(); m_addr(8'h00, ack); m_stop();
    chk("R3 general call off", ack, 0);
    wr(4'd10, 8'h01);
    m_start(); m_addr(8'h00, ack); m_stop();
    chk("R3 general call on", ack, 1);
    rd(4'd12, v); chk("R3 gc status", v, 8'h13);
    rd(4'd13, v); chk("R3 no slot bits", v, 8'h00);
    wr(4'd12, 8'h07);
  endtask

  task automatic t_arp();
    logic ack; logic [7:0] v;
    wr(4'd10, 8'h00);
    m_start(); m_addr(8'hC2, ack); m_stop();
    chk("R4 arp off", ack, 0);
    wr(4'd10, 8'h02);
    m_start(); m_addr(8'hC2, ack); m_stop();
    chk("R4 arp on", ack, 1);
    rd(4'd12, v); chk("R4 arp status", v, 8'h23);
    rd(4'd14, v); chk("R4 no slot bits", v, 8'h00);
    wr(4'd12, 8'h07);
  endtask

  task automatic t_ten();
    logic ack; logic [7:0] v;
    wr(4'd9, 8'hF8);
    m_start(); m_addr(8'hF0, ack); m_stop();
    chk("R7 10-bit header ignored", ack, 0);
    rd(4'd12, v); chk("R7 no flags", v, 8'h20);
  endtask

  task automatic t_rstart();
    logic ack; logic [7:0] v;
    m_start(); m_addr(8'h54, ack);
    chk("R1 first address", ack, 1);
    m_start(); m_addr(8'h55, ack);
    chk("R9 address after repeated start", ack, 1);
    m_stop();
    rd(4'd12, v); chk("R9 rstart flag", v, 8'h0F);
    rd(4'd13, v); chk("R2 vector low", v, 8'h08);
  endtask

  task automatic t_irq();
    wr(4'd11, 8'h00); wt(1); chk("R11 all masked", irq, 0);
    wr(4'd11, 8'h02); wt(1); chk("R11 stop unmasked", irq, 1);
    wr(4'd12, 8'h02); wt(1); chk("R11 stop cleared", irq, 0);
    wr(4'd11, 8'h07); wt(1); chk("R11 other flags", irq, 1);
    wr(4'd12, 8'h07); wt(1); chk("R11 all cleared", irq, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    wt(5); rst_n = 1'b1; wt(5);
    t_reset();
    wr(4'd3, 8'hAA);
    wr(4'd8, 8'hAA);
    wr(4'd0, 8'h50);
    t_slot_write();
    t_w1c();
    t_disabled();
    t_dir_read();
    t_gc();
    t_arp();
    t_ten();
    wr(4'd10, 8'h00);
    wr(4'd12, 8'h07);
    t_rstart();
    t_irq();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule